// File: doc/BRIEF.md
# Double Trap Routing Unit

This unit decides where a newly raised trap is delivered once the nested-trap guard bits are taken into account. It receives the trap request and its cause code, the current privilege level and virtualization mode, and the guard bits of the supervisor, virtual-supervisor and machine status registers along with the resumable-NMI enable. A trap that lands on a supervisor-level handler while that level's guard bit is set is escalated to machine mode. In that case mcause is written with 16 and the second trap's cause goes to mtval2.

A trap taken in machine mode while the machine guard bit is set is handled in one of two ways. If the resumable-NMI enable is set, it goes to the resumable NMI handler. If it is clear, the unit raises a critical-error request and does not redirect the trap.

The unit also turns commit pulses of the two return instructions into clear pulses for the guard bits. An mret back to a supervisor or virtual-supervisor level clears that level's guard bit. An mnret clears the machine guard bit. Every output is registered, so the routing decision, the cause-register writes and the status clears all appear together in the cycle after the request.

Top module: `dbl_trap_router`

## Requirements
- R1: A trap taken at privilege S (priv encoding U=0, S=1, M=3) with virt=0, delegated to the supervisor level, while the sstatus guard bit is set, is routed as a machine double trap (target code 1). It selects mtvec and does not assert the supervisor trap-register write enable.
- R2: With virt=1, the vsstatus guard bit alone decides the escalation of a delegated trap taken at privilege S, and the sstatus guard bit has no effect there. With virt=0, the vsstatus guard bit has no effect.
- R3: A machine double trap writes mcause with the value 16 and writes mtval2 with the zero-extended cause code of the second trap.
- R4: A trap taken at privilege M with the mstatus guard bit set and NMIE=1 is routed to the resumable NMI handler (target code 2). It writes neither mcause nor mtval2, does not select mtvec and does not raise a critical error.
- R5: A trap taken at privilege M with the mstatus guard bit set and NMIE=0 produces a critical-error pulse with target code 3. There is no trap redirection: no mcause or mtval2 write, no mtvec select and no supervisor register write.
- R6: When no double-trap condition holds, the trap is routed as normal (target code 0). The supervisor write enable equals the delegation input, mtvec is selected exactly when the trap is not delegated, and no cause-register write or guard-bit clear occurs.
- R7: A trap delegated to the supervisor level is never escalated when the current privilege is U or M (unless R4/R5 apply), and a non-delegated trap at S is never escalated, whatever the guard bits are.
- R8: An mret commit whose return privilege is S pulses the clear for the sstatus guard bit when the return virt bit is 0, and the clear for the vsstatus guard bit when it is 1. A return to U or M pulses neither.
- R9: An mnret commit pulses the mstatus guard-bit clear.
- R10: All outputs are zero after reset. Each output takes effect exactly one cycle after its request and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | New trap request this cycle |
| trap_cause_i | input | CAUSE_W | Cause code of the new trap |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_i | input | 1 | Current virtualization mode |
| deleg_s_i | input | 1 | Normal delegation sends the trap to the supervisor level |
| sstatus_sdt_i | input | 1 | Supervisor guard bit |
| vsstatus_sdt_i | input | 1 | Virtual-supervisor guard bit |
| mstatus_mdt_i | input | 1 | Machine guard bit |
| mnstatus_nmie_i | input | 1 | Resumable NMI enable |
| mret_i | input | 1 | mret commit pulse |
| mret_mpp_i | input | 2 | Privilege returned to by mret |
| mret_mpv_i | input | 1 | Virt mode returned to by mret |
| mnret_i | input | 1 | mnret commit pulse |
| route_valid_o | output | 1 | Routing decision valid |
| route_tgt_o | output | 2 | Target: 0 normal, 1 machine double trap, 2 resumable NMI, 3 critical |
| vec_mtvec_o | output | 1 | Vector through mtvec |
| s_trap_we_o | output | 1 | Write supervisor-level trap registers |
| mcause_we_o | output | 1 | Write mcause |
| mcause_o | output | XLEN | mcause value |
| mtval2_we_o | output | 1 | Write mtval2 |
| mtval2_o | output | XLEN | mtval2 value |
| crit_err_o | output | 1 | Critical-error request pulse |
| clr_sdt_o | output | 1 | Clear sstatus guard bit |
| clr_vsdt_o | output | 1 | Clear vsstatus guard bit |
| clr_mdt_o | output | 1 | Clear mstatus guard bit |

## Verification
The hardest case to set up is the one where the two supervisor guard bits disagree with the virtualization mode. Here a set bit of the other level must leave the trap unescalated, and this only shows if the stimulus sets the unmatched bit alone. The directed tasks drive each combination of virt and the two guard bits while holding delegation on, then repeat with delegation off and from privileges U and M. This confirms that escalation depends on the matching bit only. A trap and an mret land in the same cycle as well, to show that the clear pulse and the routing decision register together without interfering.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    TGT_NORMAL = 2'd0,
    TGT_M_DBL  = 2'd1,
    TGT_RNMI   = 2'd2,
    TGT_CRIT   = 2'd3
  } tgt_e;

  localparam int unsigned DBL_TRAP_CODE = 16;
endpackage

// File: rtl/dtr_classify.sv
module dtr_classify
  import dtr_pkg::*;
(
  input  logic       trap_valid_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       deleg_s_i,
  input  logic       sdt_i,
  input  logic       vsdt_i,
  input  logic       mdt_i,
  input  logic       nmie_i,
  output tgt_e       tgt_o,
  output logic       vec_mtvec_o,
  output logic       s_we_o,
  output logic       cause_we_o,
  output logic       crit_o
);
  logic in_s, in_m, lvl_guard, s_hit, m_hit;

  assign in_s      = (priv_i == PRIV_S);
  assign in_m      = (priv_i == PRIV_M);
  // guard bit of the level that would receive the trap
  assign lvl_guard = virt_i ? vsdt_i : sdt_i;
  assign s_hit     = in_s & deleg_s_i & lvl_guard;
  assign m_hit     = in_m & mdt_i;

  always_comb begin
    tgt_o = TGT_NORMAL;
    if (m_hit)      tgt_o = nmie_i ? TGT_RNMI : TGT_CRIT;
    else if (s_hit) tgt_o = TGT_M_DBL;
  end

  always_comb begin
    vec_mtvec_o = 1'b0;
    s_we_o      = 1'b0;
    cause_we_o  = 1'b0;
    crit_o      = 1'b0;
    if (trap_valid_i) begin
      unique case (tgt_o)
        TGT_NORMAL: begin
          vec_mtvec_o = ~deleg_s_i;
          s_we_o      = deleg_s_i;
        end
        TGT_M_DBL: begin
          vec_mtvec_o = 1'b1;
          cause_we_o  = 1'b1;
        end
        TGT_CRIT: crit_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dtr_ret_clear.sv
module dtr_ret_clear
  import dtr_pkg::*;
(
  input  logic       mret_i,
  input  logic [1:0] mpp_i,
  input  logic       mpv_i,
  input  logic       mnret_i,
  output logic       clr_sdt_o,
  output logic       clr_vsdt_o,
  output logic       clr_mdt_o
);
  logic to_s;
  assign to_s       = mret_i & (mpp_i == PRIV_S);
  assign clr_sdt_o  = to_s & ~mpv_i;
  assign clr_vsdt_o = to_s & mpv_i;
  assign clr_mdt_o  = mnret_i;
endmodule

// File: rtl/dtr_pipe_reg.sv
module dtr_pipe_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/dbl_trap_router.sv
module dbl_trap_router
  import dtr_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_valid_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               deleg_s_i,
  input  logic               sstatus_sdt_i,
  input  logic               vsstatus_sdt_i,
  input  logic               mstatus_mdt_i,
  input  logic               mnstatus_nmie_i,
  input  logic               mret_i,
  input  logic [1:0]         mret_mpp_i,
  input  logic               mret_mpv_i,
  input  logic               mnret_i,
  output logic               route_valid_o,
  output logic [1:0]         route_tgt_o,
  output logic               vec_mtvec_o,
  output logic               s_trap_we_o,
  output logic               mcause_we_o,
  output logic [XLEN-1:0]    mcause_o,
  output logic               mtval2_we_o,
  output logic [XLEN-1:0]    mtval2_o,
  output logic               crit_err_o,
  output logic               clr_sdt_o,
  output logic               clr_vsdt_o,
  output logic               clr_mdt_o
);
  // valid, tgt(2), mtvec, s_we, cause_we, crit, clr x3, cause
  localparam int unsigned CTRL_W = 10;
  localparam int unsigned REG_W  = CTRL_W + CAUSE_W;

  tgt_e c_tgt;
  logic c_mtvec, c_swe, c_cwe, c_crit;
  logic r_sdt, r_vsdt, r_mdt;
  logic [CAUSE_W-1:0] c_cause;
  logic [REG_W-1:0]   d_vec, q_vec;
  logic               q_cwe;
  logic [CAUSE_W-1:0] q_cause;

  dtr_classify u_classify (
    .trap_valid_i (trap_valid_i),
    .priv_i       (priv_i),
    .virt_i       (virt_i),
    .deleg_s_i    (deleg_s_i),
    .sdt_i        (sstatus_sdt_i),
    .vsdt_i       (vsstatus_sdt_i),
    .mdt_i        (mstatus_mdt_i),
    .nmie_i       (mnstatus_nmie_i),
    .tgt_o        (c_tgt),
    .vec_mtvec_o  (c_mtvec),
    .s_we_o       (c_swe),
    .cause_we_o   (c_cwe),
    .crit_o       (c_crit)
  );

  dtr_ret_clear u_ret_clear (
    .mret_i     (mret_i),
    .mpp_i      (mret_mpp_i),
    .mpv_i      (mret_mpv_i),
    .mnret_i    (mnret_i),
    .clr_sdt_o  (r_sdt),
    .clr_vsdt_o (r_vsdt),
    .clr_mdt_o  (r_mdt)
  );

  assign c_cause = c_cwe ? trap_cause_i : '0;

  assign d_vec = {trap_valid_i,
                  trap_valid_i ? c_tgt : TGT_NORMAL,
                  c_mtvec, c_swe, c_cwe, c_crit,
                  r_sdt, r_vsdt, r_mdt,
                  c_cause};

  dtr_pipe_reg #(.WIDTH(REG_W)) u_out_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (d_vec),
    .q_o    (q_vec)
  );

  assign route_valid_o = q_vec[REG_W-1];
  assign route_tgt_o   = q_vec[REG_W-2 -: 2];
  assign vec_mtvec_o   = q_vec[CAUSE_W+6];
  assign s_trap_we_o   = q_vec[CAUSE_W+5];
  assign q_cwe         = q_vec[CAUSE_W+4];
  assign crit_err_o    = q_vec[CAUSE_W+3];
  assign clr_sdt_o     = q_vec[CAUSE_W+2];
  assign clr_vsdt_o    = q_vec[CAUSE_W+1];
  assign clr_mdt_o     = q_vec[CAUSE_W];
  assign q_cause       = q_vec[CAUSE_W-1:0];

  assign mcause_we_o = q_cwe;
  assign mtval2_we_o = q_cwe;
  assign mcause_o    = q_cwe ? XLEN'(DBL_TRAP_CODE) : '0;
  assign mtval2_o    = XLEN'(q_cause);
endmodule

// File: rtl/dtr_chk.sv
module dtr_chk #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               trap_valid_i,
  input logic [1:0]         priv_i,
  input logic               virt_i,
  input logic               deleg_s_i,
  input logic               sstatus_sdt_i,
  input logic               mstatus_mdt_i,
  input logic               mnstatus_nmie_i,
  input logic               mnret_i,
  input logic               route_valid_o,
  input logic [1:0]         route_tgt_o,
  input logic               s_trap_we_o,
  input logic               mcause_we_o,
  input logic [XLEN-1:0]    mcause_o,
  input logic               mtval2_we_o,
  input logic               crit_err_o,
  input logic               clr_mdt_o
);
  // R1
  s_dbl_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && priv_i == 2'd1 && !virt_i && deleg_s_i && sstatus_sdt_i)
    |=> (route_valid_o && route_tgt_o == 2'd1 && !s_trap_we_o));

  // R3
  dbl_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_valid_o && route_tgt_o == 2'd1)
    |-> (mcause_we_o && mtval2_we_o && mcause_o == XLEN'(16)));

  // R5
  crit_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && priv_i == 2'd3 && mstatus_mdt_i && !mnstatus_nmie_i)
    |=> (crit_err_o && !mcause_we_o && !s_trap_we_o));

  // R4
  rnmi_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_valid_o && route_tgt_o == 2'd2) |-> (!mcause_we_o && !crit_err_o));

  // R9
  mnret_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mnret_i |=> clr_mdt_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_valid_o |-> (!mcause_we_o && !s_trap_we_o && !crit_err_o));
endmodule

bind dbl_trap_router dtr_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dtr_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .trap_valid_i    (trap_valid_i),
  .priv_i          (priv_i),
  .virt_i          (virt_i),
  .deleg_s_i       (deleg_s_i),
  .sstatus_sdt_i   (sstatus_sdt_i),
  .mstatus_mdt_i   (mstatus_mdt_i),
  .mnstatus_nmie_i (mnstatus_nmie_i),
  .mnret_i         (mnret_i),
  .route_valid_o   (route_valid_o),
  .route_tgt_o     (route_tgt_o),
  .s_trap_we_o     (s_trap_we_o),
  .mcause_we_o     (mcause_we_o),
  .mcause_o        (mcause_o),
  .mtval2_we_o     (mtval2_we_o),
  .crit_err_o      (crit_err_o),
  .clr_mdt_o       (clr_mdt_o)
);

// File: tb/dbl_trap_router_bench.sv
`timescale 1ns/1ps
module dbl_trap_router_bench;
  localparam int XLEN = 64;
  localparam int CW   = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tv = 0; logic [CW-1:0] cause = '0; logic [1:0] priv = 0;
  logic virt = 0, deleg = 0, sdt = 0, vsdt = 0, mdt = 0, nmie = 0;
  logic mret = 0; logic [1:0] mpp = 0; logic mpv = 0; logic mnret = 0;
  logic rv, vmt, swe, mcwe, m2we, crit, csdt, cvsdt, cmdt;
  logic [1:0] tgt;
  logic [XLEN-1:0] mcause, mtval2;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dbl_trap_router #(.XLEN(XLEN), .CAUSE_W(CW)) u_dbl_trap_router (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(tv), .trap_cause_i(cause),
    .priv_i(priv), .virt_i(virt), .deleg_s_i(deleg), .sstatus_sdt_i(sdt),
    .vsstatus_sdt_i(vsdt), .mstatus_mdt_i(mdt), .mnstatus_nmie_i(nmie),
    .mret_i(mret), .mret_mpp_i(mpp), .mret_mpv_i(mpv), .mnret_i(mnret),
    .route_valid_o(rv), .route_tgt_o(tgt), .vec_mtvec_o(vmt),
    .s_trap_we_o(swe), .mcause_we_o(mcwe), .mcause_o(mcause),
    .mtval2_we_o(m2we), .mtval2_o(mtval2), .crit_err_o(crit),
    .clr_sdt_o(csdt), .clr_vsdt_o(cvsdt), .clr_mdt_o(cmdt));

  task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected outputs derived from the target code
  task automatic trap(string req, logic [1:0] p, logic v, logic d, logic s, logic vs,
                      logic m, logic n, logic [CW-1:0] c, logic [1:0] etgt);
    @(negedge clk);
    tv = 1; priv = p; virt = v; deleg = d; sdt = s; vsdt = vs; mdt = m; nmie = n; cause = c;
    @(negedge clk);
    tv = 0;
    chk(req, "valid", XLEN'(rv), 1);
    chk(req, "tgt", XLEN'(tgt), XLEN'(etgt));
    chk(req, "mtvec", XLEN'(vmt), XLEN'(etgt == 1 || (etgt == 0 && !d)));
    chk(req, "s_we", XLEN'(swe), XLEN'(etgt == 0 && d));
    chk(req, "mcause_we", XLEN'(mcwe), XLEN'(etgt == 1));
    chk(req, "mtval2_we", XLEN'(m2we), XLEN'(etgt == 1));
    if (etgt == 1) begin
      chk(req, "mcause", mcause, 16);
      chk(req, "mtval2", mtval2, XLEN'(c));
    end
    chk(req, "crit", XLEN'(crit), XLEN'(etgt == 3));
    chk(req, "no_clr", XLEN'({csdt, cvsdt, cmdt}), 0);
    @(negedge clk);
    chk("R10", "pulse_end", XLEN'({rv, crit, mcwe}), 0);
  endtask

  task automatic t_reset();
    chk("R10", "reset_valid", XLEN'(rv), 0);
    chk("R10", "reset_outs", XLEN'({tgt, vmt, swe, mcwe, m2we, crit, csdt, cvsdt, cmdt}), 0);
    chk("R10", "reset_vals", mcause | mtval2, 0);
  endtask

  task automatic t_s_dbl();
    trap("R1", 2'd1, 0, 1, 1, 0, 0, 0, 6'd13, 2'd1);
    trap("R3", 2'd1, 0, 1, 1, 1, 0, 1, 6'd63, 2'd1);
  endtask

  task automatic t_vs_dbl();
    trap("R2", 2'd1, 1, 1, 0, 1, 0, 0, 6'd8, 2'd1);
    trap("R2", 2'd1, 1, 1, 1, 0, 0, 0, 6'd8, 2'd0);
    trap("R2", 2'd1, 0, 1, 0, 1, 0, 0, 6'd8, 2'd0);
  endtask

  task automatic t_m_dbl();
    trap("R4", 2'd3, 0, 0, 0, 0, 1, 1, 6'd2, 2'd2);
    trap("R5", 2'd3, 0, 0, 1, 1, 1, 0, 6'd5, 2'd3);
  endtask

  task automatic t_normal();
    trap("R6", 2'd0, 0, 1, 0, 0, 0, 0, 6'd3, 2'd0);
    trap("R6", 2'd3, 0, 0, 0, 0, 0, 0, 6'd11, 2'd0);
    trap("R7", 2'd1, 0, 0, 1, 1, 0, 0, 6'd7, 2'd0);
    trap("R7", 2'd0, 0, 1, 1, 1, 0, 1, 6'd7, 2'd0);
    trap("R7", 2'd3, 0, 1, 1, 1, 0, 0, 6'd7, 2'd0);
  endtask

  task automatic ret(string req, logic r, logic [1:0] p, logic v, logic nr, logic [2:0] exp);
    @(negedge clk);
    mret = r; mpp = p; mpv = v; mnret = nr;
    @(negedge clk);
    mret = 0; mnret = 0;
    chk(req, "clr{s,vs,m}", XLEN'({csdt, cvsdt, cmdt}), XLEN'(exp));
    chk(req, "no_route", XLEN'(rv), 0);
    @(negedge clk);
    chk("R10", "clr_end", XLEN'({csdt, cvsdt, cmdt}), 0);
  endtask

  task automatic t_returns();
    ret("R8", 1, 2'd1, 0, 0, 3'b100);
    ret("R8", 1, 2'd1, 1, 0, 3'b010);
    ret("R8", 1, 2'd0, 0, 0, 3'b000);
    ret("R8", 1, 2'd3, 1, 0, 3'b000);
    ret("R9", 0, 2'd0, 0, 1, 3'b001);
  endtask

  // trap and mret in the same cycle
  task automatic t_overlap();
    @(negedge clk);
    tv = 1; priv = 2'd1; virt = 1; deleg = 1; sdt = 0; vsdt = 1; mdt = 0; nmie = 0;
    cause = 6'd21; mret = 1; mpp = 2'd1; mpv = 1;
    @(negedge clk);
    tv = 0; mret = 0;
    chk("R2", "ovl_tgt", XLEN'(tgt), 1);
    chk("R3", "ovl_mtval2", mtval2, 21);
    chk("R8", "ovl_clr", XLEN'({csdt, cvsdt, cmdt}), XLEN'(3'b010));
  endtask

  initial begin
    #1;
    t_reset();
    #10 rst_n = 1;
    t_s_dbl();
    t_vs_dbl();
    t_m_dbl();
    t_normal();
    t_returns();
    t_overlap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule